// File: doc/BRIEF.md
# Configuration Register Readback Sequence Detector

This block sits on the device side of an asynchronous-style memory bus. It watches the chip-enable, output-enable and write-enable strobes, a 22-bit address and a 16-bit data bus. It recognises a fixed six-access pattern aimed at the highest address. The pattern is one read, then three writes, with bit 0 of the last write cleared. When it sees that pattern, the next two accesses return two stored configuration words instead of array data: the second word first, then the third. The second word holds refresh-coverage, burst, operating-function and output-drive settings. The third word holds latency, write-mode, clock-edge, asynchronous-fallback and write-strobe-control settings.

The strobes pass through a two-flop synchroniser. The block counts a bus cycle on every rising edge of the synchronised chip-enable. A broken prefix returns the tracker to idle. Once the three-cycle prefix is complete, the sequence is committed and always consumes three more cycles. This holds even if the fourth access does not qualify; in that case nothing is driven. The configuration words and a flag saying whether they were ever set come from outside the block. If the flag is low, the readback drives zero and marks the data untrusted.

Top module: `mr_seq_detect`

## Requirements
- R1: Only the all-ones address 0x3FFFFF counts toward the pattern. An access at any other address breaks an uncommitted prefix and disqualifies the fourth access.
- R2: A bus cycle ends on each rising edge of the synchronised chip-enable. A cycle is classified as follows: a read if output-enable went low and write-enable did not; a write if write-enable went low and output-enable did not; illegal if both or neither went low.
- R3: After the prefix read, write, write, followed by a write whose data bit 0 is 0, the fifth cycle drives configuration word 2 and the sixth cycle drives configuration word 3. Driving happens only while the synchronised chip-enable and output-enable are low and write-enable is high.
- R4: The data values on the first three accesses have no influence on the pattern.
- R5: After three correct prefix cycles, `seq_locked` goes high and the next three cycles are always consumed. If the fourth cycle is not a top-address write with bit 0 clear, cycles five and six drive nothing. If the fourth cycle qualifies, a write in cycle five does not stop cycle six from returning word 3.
- R6: Any other access during steps one or two of the prefix sends the tracker to idle. If that access is itself a read of the top address, it counts as a new first step.
- R7: After the sixth cycle the tracker is idle and `seq_locked` is low. A further read of the top address starts only a new first step and drives nothing.
- R8: While `code_set` is low, a readback still asserts `dq_drive` but holds `dq_out` at zero and `dq_trusted` low.
- R9: Outside a readback, `dq_drive` and `dq_trusted` are low and `dq_out` is zero. This includes the state right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | 22 | Bus address, stable while chip-enable is low |
| dq_in | input | 16 | Write data from the bus |
| code2_word | input | 16 | Stored configuration word 2 |
| code3_word | input | 16 | Stored configuration word 3 |
| code_set | input | 1 | High once the configuration words hold programmed values |
| dq_out | output | 16 | Readback data |
| dq_drive | output | 1 | High while the block owns the data bus |
| dq_trusted | output | 1 | Readback data is a programmed value |
| seq_locked | output | 1 | The sequence is committed to its last three cycles |

## Verification
The strobes take two clock edges to reach the tracker. Readback data appears combinationally from the registered step and the synchronised strobes, so it is valid two to three clocks after output-enable falls. The step advances about three clocks after chip-enable rises. The bench therefore holds each strobe low for five falling edges before it samples `dq_drive`, `dq_out` and `dq_trusted`. It keeps chip-enable high for seven clocks before the next access, so every step update has landed before the next cycle is checked. `seq_locked` is sampled in this idle gap, after the step has settled.

// File: rtl/mr_seq_pkg.sv
package mr_seq_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_BAD   = 2'd2
    } acc_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_GOT1  = 4'd1,
        ST_GOT2  = 4'd2,
        ST_GOT3  = 4'd3,
        ST_RD5   = 4'd4,
        ST_RD6   = 4'd5,
        ST_SKIP5 = 4'd6,
        ST_SKIP6 = 4'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_NONE  = 2'd0,
        PH_WORD2 = 2'd1,
        PH_WORD3 = 2'd2
    } rd_phase_e;

    typedef struct packed {
        logic      done;
        acc_kind_e kind;
        logic      top;
        logic      bit0;
    } bus_cycle_t;

    function automatic acc_kind_e classify(input logic saw_oe, input logic saw_we);
        if (saw_oe && !saw_we)      return ACC_READ;
        else if (saw_we && !saw_oe) return ACC_WRITE;
        else                        return ACC_BAD;
    endfunction

    function automatic logic is_locked(input seq_state_e s);
        return (s == ST_GOT3) || (s == ST_RD5) || (s == ST_RD6) ||
               (s == ST_SKIP5) || (s == ST_SKIP6);
    endfunction

endpackage

// File: rtl/mr_bus_sampler.sv
module mr_bus_sampler
    import mr_seq_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dq_bit0,
    output bus_cycle_t        cyc,
    output logic              active,
    output logic              oe_act,
    output logic              we_act
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] ce_sh, oe_sh, we_sh;
    logic ce_prev;
    logic saw_oe, saw_we, top_l, bit0_l;
    logic rise;

    // strobe synchronisers, reset to the inactive level
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_sh   <= '1;
            oe_sh   <= '1;
            we_sh   <= '1;
            ce_prev <= 1'b1;
        end else begin
            ce_sh   <= {ce_sh[TOP-1:0], ce_n};
            oe_sh   <= {oe_sh[TOP-1:0], oe_n};
            we_sh   <= {we_sh[TOP-1:0], we_n};
            ce_prev <= ce_sh[TOP];
        end
    end

    assign active = ~ce_sh[TOP];
    assign oe_act = active & ~oe_sh[TOP];
    assign we_act = active & ~we_sh[TOP];
    assign rise   = ce_sh[TOP] & ~ce_prev;

    // per-cycle capture of strobe activity, address match and write bit 0
    always_ff @(posedge clk) begin
        if (rst) begin
            saw_oe <= 1'b0;
            saw_we <= 1'b0;
            top_l  <= 1'b0;
            bit0_l <= 1'b0;
        end else if (rise) begin
            saw_oe <= 1'b0;
            saw_we <= 1'b0;
            top_l  <= 1'b0;
            bit0_l <= 1'b0;
        end else if (active) begin
            if (oe_act) saw_oe <= 1'b1;
            if (we_act) begin
                saw_we <= 1'b1;
                bit0_l <= dq_bit0;
            end
            top_l <= &addr;
        end
    end

    always_comb begin
        cyc.done = rise;
        cyc.kind = classify(saw_oe, saw_we);
        cyc.top  = top_l;
        cyc.bit0 = bit0_l;
    end

    AST_CYCLE_END_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        cyc.done |=> !cyc.done); // R2

endmodule

// File: rtl/mr_seq_fsm.sv
module mr_seq_fsm
    import mr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_cycle_t cyc,
    output rd_phase_e  phase,
    output logic       locked
);

    seq_state_e state, state_nx;
    logic rd_top, wr_top, wr_arm;

    assign rd_top = (cyc.kind == ACC_READ)  && cyc.top;
    assign wr_top = (cyc.kind == ACC_WRITE) && cyc.top;
    assign wr_arm = wr_top && !cyc.bit0;

    always_comb begin
        state_nx = state;
        if (cyc.done) begin
            unique case (state)
                ST_IDLE:  state_nx = rd_top ? ST_GOT1 : ST_IDLE;
                ST_GOT1:  state_nx = wr_top ? ST_GOT2 : (rd_top ? ST_GOT1 : ST_IDLE);
                ST_GOT2:  state_nx = wr_top ? ST_GOT3 : (rd_top ? ST_GOT1 : ST_IDLE);
                ST_GOT3:  state_nx = wr_arm ? ST_RD5 : ST_SKIP5;
                ST_RD5:   state_nx = ST_RD6;
                ST_RD6:   state_nx = ST_IDLE;
                ST_SKIP5: state_nx = ST_SKIP6;
                ST_SKIP6: state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_RD5:  phase = PH_WORD2;
            ST_RD6:  phase = PH_WORD3;
            default: phase = PH_NONE;
        endcase
    end

    assign locked = is_locked(state);

    AST_LOCK_RUNS_OUT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GOT3 && cyc.done) |=> (state == ST_RD5 || state == ST_SKIP5)); // R5

    AST_WORD3_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD5 && cyc.done) |=> (state == ST_RD6)); // R3

    AST_PREFIX_BREAK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GOT1 && cyc.done && !wr_top && !rd_top) |=> (state == ST_IDLE)); // R6

    AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD6 && cyc.done) |=> !locked); // R7

endmodule

// File: rtl/mr_read_mux.sv
module mr_read_mux
    import mr_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  rd_phase_e         phase,
    input  logic              oe_act,
    input  logic              we_act,
    input  logic [DATA_W-1:0] word2,
    input  logic [DATA_W-1:0] word3,
    input  logic              words_set,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive,
    output logic              dq_trusted
);

    logic [DATA_W-1:0] pick;

    always_comb begin
        unique case (phase)
            PH_WORD2: pick = word2;
            PH_WORD3: pick = word3;
            default:  pick = '0;
        endcase
    end

    assign dq_drive   = (phase != PH_NONE) && oe_act && !we_act;
    assign dq_trusted = dq_drive && words_set;
    assign dq_out     = dq_trusted ? pick : '0;

endmodule

// File: rtl/mr_seq_detect.sv
module mr_seq_detect
    import mr_seq_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [DATA_W-1:0] code2_word,
    input  logic [DATA_W-1:0] code3_word,
    input  logic              code_set,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive,
    output logic              dq_trusted,
    output logic              seq_locked
);

    bus_cycle_t cyc;
    rd_phase_e  phase;
    logic       active, oe_act, we_act;
    logic [DATA_W-2:0] dq_hi_unused;

    assign dq_hi_unused = dq_in[DATA_W-1:1];

    mr_bus_sampler #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_bit0(dq_in[0]), .cyc(cyc),
        .active(active), .oe_act(oe_act), .we_act(we_act)
    );

    mr_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .cyc(cyc), .phase(phase), .locked(seq_locked)
    );

    mr_read_mux #(.DATA_W(DATA_W)) u_mux (
        .phase(phase), .oe_act(oe_act), .we_act(we_act),
        .word2(code2_word), .word3(code3_word), .words_set(code_set),
        .dq_out(dq_out), .dq_drive(dq_drive), .dq_trusted(dq_trusted)
    );

    AST_UNSET_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !code_set |-> (!dq_trusted && dq_out == '0)); // R8

    AST_DRIVE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        dq_drive |-> (seq_locked && active)); // R9

endmodule

// File: tb/mr_seq_detect_bench.sv
module mr_seq_detect_bench;

    localparam logic [21:0] T  = 22'h3FFFFF;
    localparam logic [15:0] C2 = 16'hA5C3;
    localparam logic [15:0] C3 = 16'h1E77;
    // op: 0 read, 1 write, 2 both strobes; exp: 0 none, 2 word 2, 3 word 3
    localparam int NV = 39;
    localparam logic [41:0] VEC [NV] = '{
        {2'd0, T, 16'h0000, 2'd0},          // R3 step 1
        {2'd1, T, 16'hFFFF, 2'd0},          // R4 data ignored
        {2'd1, T, 16'h1234, 2'd0},
        {2'd1, T, 16'hFFFE, 2'd0},          // bit0 clear
        {2'd0, T, 16'h0000, 2'd2},          // R3 word 2
        {2'd0, T, 16'h0000, 2'd3},          // R3 word 3
        {2'd0, T, 16'h0000, 2'd0},          // R7 only step 1
        {2'd1, 22'h3FFFFE, 16'h0000, 2'd0}, // R1 break
        {2'd0, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},
        {2'd0, T, 16'h0000, 2'd0},          // R6 restart
        {2'd1, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0001, 2'd0},          // R5 bad fourth
        {2'd0, T, 16'h0000, 2'd0},
        {2'd0, T, 16'h0000, 2'd0},
        {2'd0, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},
        {2'd1, 22'h000000, 16'h0000, 2'd0}, // R1 wrong fourth address
        {2'd0, T, 16'h0000, 2'd0},
        {2'd0, T, 16'h0000, 2'd0},
        {2'd0, T, 16'h0000, 2'd0},
        {2'd2, T, 16'h0000, 2'd0},          // R2 illegal access
        {2'd1, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},
        {2'd0, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},          // R5 write in cycle 5
        {2'd0, T, 16'h0000, 2'd3},
        {2'd0, T, 16'h5555, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},
        {2'd1, T, 16'h0000, 2'd0},
        {2'd0, T, 16'h0000, 2'd2},
        {2'd0, T, 16'h0000, 2'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [21:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] code2_word = C2, code3_word = C3;
    logic code_set = 1'b1;
    logic [15:0] dq_out;
    logic dq_drive, dq_trusted, seq_locked;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mr_seq_detect u_mr_seq_detect (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .code2_word(code2_word),
        .code3_word(code3_word), .code_set(code_set), .dq_out(dq_out),
        .dq_drive(dq_drive), .dq_trusted(dq_trusted), .seq_locked(seq_locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] k, input logic [21:0] a, input logic [15:0] d,
                         input logic [1:0] e, input logic set_exp, input string tag);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = 1'b0;
        repeat (2) @(negedge clk);
        if (k != 2'd1) oe_n = 1'b0;
        if (k != 2'd0) we_n = 1'b0;
        repeat (5) @(negedge clk);
        if (e == 2'd0) begin
            chk({tag, " R9 drive"}, 32'(dq_drive), 32'd0);
            chk({tag, " R9 data"}, 32'(dq_out), 32'd0);
        end else begin
            chk({tag, " R3 drive"}, 32'(dq_drive), 32'd1);
            chk({tag, " R8 trusted"}, 32'(dq_trusted), 32'(set_exp));
            chk({tag, " R3 data"}, 32'(dq_out),
                set_exp ? 32'(e == 2'd2 ? C2 : C3) : 32'd0);
        end
        oe_n = 1'b1; we_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b1;
        repeat (7) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset drive", 32'(dq_drive), 32'd0);
        chk("R9 reset data", 32'(dq_out), 32'd0);
        chk("R7 reset lock", 32'(seq_locked), 32'd0);

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][41:40], VEC[i][39:18], VEC[i][17:2], VEC[i][1:0], 1'b1,
                  $sformatf("R1/R2/R5/R6 vec %0d", i));
        end

        // directed: lock flag and unset words
        code_set = 1'b0;
        do_op(2'd0, T, 16'h0000, 2'd0, 1'b0, "R5 pre");
        do_op(2'd1, T, 16'h0000, 2'd0, 1'b0, "R5 pre");
        chk("R5 not yet locked", 32'(seq_locked), 32'd0);
        do_op(2'd1, T, 16'h0000, 2'd0, 1'b0, "R5 pre");
        chk("R5 locked after prefix", 32'(seq_locked), 32'd1);
        do_op(2'd1, T, 16'h0000, 2'd0, 1'b0, "R5 arm");
        do_op(2'd0, T, 16'h0000, 2'd2, 1'b0, "R8 unset word2");
        do_op(2'd0, T, 16'h0000, 2'd3, 1'b0, "R8 unset word3");
        chk("R7 unlocked after cycle 6", 32'(seq_locked), 32'd0);

        // directed: reset mid-sequence clears the tracker
        code_set = 1'b1;
        do_op(2'd0, T, 16'h0000, 2'd0, 1'b1, "R9 pre");
        do_op(2'd1, T, 16'h0000, 2'd0, 1'b1, "R9 pre");
        do_op(2'd1, T, 16'h0000, 2'd0, 1'b1, "R9 pre");
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset clears lock", 32'(seq_locked), 32'd0);
        do_op(2'd1, T, 16'h0000, 2'd0, 1'b1, "R9 after reset");
        do_op(2'd0, T, 16'h0000, 2'd0, 1'b1, "R9 after reset");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule